// File: doc/BRIEF.md
# Mask-Gated Byte Summation Unit

This block replaces a byte-by-byte multiply with conditional addition. It takes eight unsigned byte operands and a 64-bit binary mask. It produces eight lane results. Each lane adds the subset of the eight bytes picked out by its own 8-bit slice of the mask. A mask bit that is clear contributes zero. Typical use is one bit-plane of a low-precision matrix product. Software repeats the operation for each plane, then weights and combines the lane results outside the inner loop. The plane count can be cut short when fewer bits of precision are enough.

Two variants sit on top of the plain sum. An operand-field select makes each byte contribute only its lower or upper four bits, zero-extended. This keeps the plain sum within 7 bits. An accumulate option adds each lane's sum to a caller-supplied previous lane value and reports a per-lane carry-out. One operation covers exactly one 64-bit chunk. Wider vectors issue one operation per chunk, each chunk with its own eight bytes. The results are registered, so each operation takes one cycle.

Top module: `bbs_mask_sum`

## Requirements
- R1: Byte operand i sits in `opnd_i[8i+7:8i]`. Output lane j sits in `sum_o[16j+15:16j]`. With `mode_i[1:0]` equal to 0 or 3 and `mode_i[2]`=0, lane j equals the sum of every byte i whose mask bit `mask_i[8j+i]` is 1.
- R2: Without accumulation (`mode_i[2]`=0), each lane holds the unsigned sum zero-extended to 16 bits. The largest value is 2040, and `ovf_o` is 0 for every lane.
- R3: With `mode_i[1:0]`=1 (low field), each selected byte contributes only its bits [3:0]. A plain lane sum is therefore at most 120.
- R4: With `mode_i[1:0]`=2 (high field), each selected byte contributes its bits [7:4] as an unshifted value from 0 to 15.
- R5: With `mode_i[2]`=1, lane j equals (`acc_i[16j+15:16j]` + conditional sum) modulo 65536. The field select of R1, R3 and R4 still applies.
- R6: In accumulate mode, `ovf_o[j]` is 1 exactly when that lane's addition carries out of bit 15.
- R7: `valid_o` is 1 in the cycle after a clock edge that sampled `valid_i`=1, and 0 after an edge that sampled `valid_i`=0. The results of an accepted operation are visible together with that `valid_o`.
- R8: While `valid_i` is 0, `sum_o` and `ovf_o` keep their previous values, whatever the other inputs do.
- R9: After reset (`rst_ni` low), `valid_o`, every lane of `sum_o` and every bit of `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation on this edge |
| opnd_i | input | 64 | Eight byte operands, operand i in bits [8i+7:8i] |
| mask_i | input | 64 | Gate bits, bit 8j+i gates operand i into lane j |
| mode_i | input | 3 | [1:0] operand field (0/3 byte, 1 low nibble, 2 high nibble), [2] accumulate |
| acc_i | input | 128 | Previous lane values, lane j in bits [16j+15:16j] |
| valid_o | output | 1 | Results of an accepted operation are present |
| sum_o | output | 128 | Lane results, lane j in bits [16j+15:16j] |
| ovf_o | output | 8 | Per-lane carry-out of the accumulate addition |

## Verification
Every result, including `valid_o`, the sums and the carry flags, is due one clock edge after the edge that accepts `valid_i`. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares all lanes on the following falling edge, well away from the edge that updates them. For the hold behaviour, the bench drives new data with `valid_i` low for a full cycle and checks on the next falling edge that the outputs have not moved and that `valid_o` has dropped.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   // Operand field select, taken from mode_i[1:0]
   typedef enum logic [1:0] {
      FLD_BYTE     = 2'd0,
      FLD_LOW      = 2'd1,
      FLD_HIGH     = 2'd2,
      FLD_BYTE_ALT = 2'd3
   } field_e;

   localparam int unsigned MODE_W   = 3;
   localparam int unsigned MODE_ACC = 2;

endpackage

// File: rtl/bbs_field_sel.sv
module bbs_field_sel
   import bbs_pkg::*;
#(
   parameter int unsigned NOPS = 8,
   parameter int unsigned OPW  = 8
) (
   input  field_e                  fld_i,
   input  logic [NOPS*OPW-1:0]     opnd_i,
   output logic [NOPS*OPW-1:0]     sel_o
);

   localparam int unsigned HALF = OPW / 2;

   if ((OPW % 2) != 0 || OPW < 2) begin : g_bad_opw
      $error("bbs_field_sel: OPW must be even and at least 2");
   end

   for (genvar i = 0; i < NOPS; i++) begin : g_op
      logic [OPW-1:0] byte_v;
      assign byte_v = opnd_i[i*OPW +: OPW];
      always_comb begin
         unique case (fld_i)
            FLD_LOW:  sel_o[i*OPW +: OPW] = {{(OPW-HALF){1'b0}}, byte_v[HALF-1:0]};
            FLD_HIGH: sel_o[i*OPW +: OPW] = {{(OPW-HALF){1'b0}}, byte_v[OPW-1:HALF]};
            default:  sel_o[i*OPW +: OPW] = byte_v;
         endcase
      end
   end

endmodule

// File: rtl/bbs_lane_sum.sv
module bbs_lane_sum #(
   parameter int unsigned NOPS  = 8,
   parameter int unsigned OPW   = 8,
   parameter int unsigned RAW_W = OPW + $clog2(NOPS)
) (
   input  logic [NOPS*OPW-1:0] ops_i,
   input  logic [NOPS-1:0]     gate_i,
   output logic [RAW_W-1:0]    sum_o
);

   if (RAW_W < OPW + $clog2(NOPS)) begin : g_bad_raw
      $error("bbs_lane_sum: RAW_W too narrow for NOPS operands");
   end

   always_comb begin
      sum_o = '0;
      for (int i = 0; i < NOPS; i++) begin
         if (gate_i[i]) begin
            sum_o = sum_o + RAW_W'(ops_i[i*OPW +: OPW]);
         end
      end
   end

endmodule

// File: rtl/bbs_lane_accum.sv
module bbs_lane_accum #(
   parameter int unsigned RAW_W = 11,
   parameter int unsigned ACCW  = 16
) (
   input  logic [RAW_W-1:0] raw_i,
   input  logic [ACCW-1:0]  acc_i,
   input  logic             acc_en_i,
   output logic [ACCW-1:0]  res_o,
   output logic             carry_o
);

   localparam int unsigned EW = ACCW + 1;

   if (ACCW < RAW_W) begin : g_bad_accw
      $error("bbs_lane_accum: ACCW must hold a full lane sum");
   end

   logic [EW-1:0] total;

   always_comb begin
      if (acc_en_i) begin
         total = EW'(acc_i) + EW'(raw_i);
      end else begin
         total = EW'(raw_i);
      end
   end

   assign res_o   = total[ACCW-1:0];
   assign carry_o = total[ACCW];

endmodule

// File: rtl/bbs_mask_sum.sv
module bbs_mask_sum
   import bbs_pkg::*;
#(
   parameter int unsigned LANES = 8,
   parameter int unsigned OPW   = 8,
   parameter int unsigned ACCW  = 16
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   valid_i,
   input  logic [LANES*OPW-1:0]   opnd_i,
   input  logic [LANES*LANES-1:0] mask_i,
   input  logic [2:0]             mode_i,
   input  logic [LANES*ACCW-1:0]  acc_i,
   output logic                   valid_o,
   output logic [LANES*ACCW-1:0]  sum_o,
   output logic [LANES-1:0]       ovf_o
);

   localparam int unsigned RAW_W    = OPW + $clog2(LANES);
   localparam int unsigned HALF     = OPW / 2;
   localparam int unsigned FULL_MAX = LANES * ((1 << OPW) - 1);
   localparam int unsigned NIB_MAX  = LANES * ((1 << HALF) - 1);
   localparam int unsigned EW       = ACCW + 1;

   if (LANES < 2) begin : g_bad_lanes
      $error("bbs_mask_sum: LANES must be at least 2");
   end
   if (ACCW < RAW_W) begin : g_bad_accw
      $error("bbs_mask_sum: ACCW narrower than a lane sum");
   end

   field_e                  fld;
   logic                    acc_en;
   logic [LANES*OPW-1:0]    sel_ops;
   logic [RAW_W-1:0]        raw_sum [LANES];
   logic [ACCW-1:0]         lane_res [LANES];
   logic [LANES-1:0]        lane_carry;

   assign fld    = field_e'(mode_i[1:0]);
   assign acc_en = mode_i[MODE_ACC];

   bbs_field_sel #(
      .NOPS (LANES),
      .OPW  (OPW)
   ) u_field (
      .fld_i  (fld),
      .opnd_i (opnd_i),
      .sel_o  (sel_ops)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      bbs_lane_sum #(
         .NOPS  (LANES),
         .OPW   (OPW),
         .RAW_W (RAW_W)
      ) u_sum (
         .ops_i  (sel_ops),
         .gate_i (mask_i[j*LANES +: LANES]),
         .sum_o  (raw_sum[j])
      );

      bbs_lane_accum #(
         .RAW_W (RAW_W),
         .ACCW  (ACCW)
      ) u_acc (
         .raw_i    (raw_sum[j]),
         .acc_i    (acc_i[j*ACCW +: ACCW]),
         .acc_en_i (acc_en),
         .res_o    (lane_res[j]),
         .carry_o  (lane_carry[j])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sum_o[j*ACCW +: ACCW] <= '0;
            ovf_o[j]              <= 1'b0;
         end else if (valid_i) begin
            sum_o[j*ACCW +: ACCW] <= lane_res[j];
            ovf_o[j]              <= lane_carry[j];
         end
      end

      AST_PLAIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_i && !mode_i[MODE_ACC] |=> (32'(sum_o[j*ACCW +: ACCW]) <= FULL_MAX) && !ovf_o[j]); // R2

      AST_NIBBLE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_i && !mode_i[MODE_ACC] && (mode_i[1:0] == 2'd1 || mode_i[1:0] == 2'd2)
         |=> 32'(sum_o[j*ACCW +: ACCW]) <= NIB_MAX); // R3

      AST_ACCUM_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_i && mode_i[MODE_ACC]
         |=> {ovf_o[j], sum_o[j*ACCW +: ACCW]} ==
             ($past(EW'(acc_i[j*ACCW +: ACCW])) + $past(EW'(raw_sum[j])))); // R5
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
      end else begin
         valid_o <= valid_i;
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R7

   AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(sum_o) && $stable(ovf_o)); // R8

endmodule

// File: tb/bbs_mask_sum_tb.sv
module bbs_mask_sum_tb;

   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         valid_i = 1'b0;
   logic [63:0]  opnd_i = '0;
   logic [63:0]  mask_i = '0;
   logic [2:0]   mode_i = '0;
   logic [127:0] acc_i = '0;
   logic         valid_o;
   logic [127:0] sum_o;
   logic [7:0]   ovf_o;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   logic [127:0] exp_sum;
   logic [7:0]   exp_ovf;

   always #10 clk_i = ~clk_i;

   bbs_mask_sum u_dut (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .opnd_i  (opnd_i),
      .mask_i  (mask_i),
      .mode_i  (mode_i),
      .acc_i   (acc_i),
      .valid_o (valid_o),
      .sum_o   (sum_o),
      .ovf_o   (ovf_o)
   );

   function automatic logic [16:0] ref_lane(input logic [63:0] a, input logic [63:0] m,
                                            input int j, input logic [2:0] md,
                                            input logic [15:0] acc);
      int s = 0;
      int tot;
      for (int i = 0; i < 8; i++) begin
         if (m[8*j+i]) begin
            int b = int'(a[8*i +: 8]);
            if (md[1:0] == 2'd1)      s += b % 16;
            else if (md[1:0] == 2'd2) s += b / 16;
            else                      s += b;
         end
      end
      if (md[2]) begin
         tot = int'(acc) + s;
         return {tot > 65535, 16'(tot % 65536)};
      end
      return {1'b0, 16'(s)};
   endfunction

   task automatic check(input string tag, input logic [127:0] got_s, input logic [127:0] want_s,
                        input logic [7:0] got_o, input logic [7:0] want_o,
                        input logic got_v, input logic want_v);
      n_checks++;
      if (got_s !== want_s || got_o !== want_o || got_v !== want_v) begin
         n_fail++;
         $display("FAIL %s: sum=%h ovf=%h valid=%b, expected sum=%h ovf=%h valid=%b",
                  tag, got_s, got_o, got_v, want_s, want_o, want_v);
      end
   endtask

   task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] m,
                         input logic [2:0] md, input logic [127:0] acc);
      @(negedge clk_i);
      opnd_i  = a;
      mask_i  = m;
      mode_i  = md;
      acc_i   = acc;
      valid_i = 1'b1;
      for (int j = 0; j < 8; j++) begin
         logic [16:0] r = ref_lane(a, m, j, md, acc[16*j +: 16]);
         exp_sum[16*j +: 16] = r[15:0];
         exp_ovf[j] = r[16];
      end
      @(posedge clk_i);
      @(negedge clk_i);
      valid_i = 1'b0;
      check(tag, sum_o, exp_sum, ovf_o, exp_ovf, valid_o, 1'b1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk_i);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      logic [127:0] hold_s;
      logic [7:0]   hold_o;
      void'($urandom(32'd12345));
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      check("R9 reset state", sum_o, '0, ovf_o, '0, valid_o, 1'b0);
      rst_ni = 1'b1;

      // R1 R2: every byte 0xFF, full mask -> 2040 per lane
      run_op("R2 full-scale sum", {8{8'hFF}}, {64{1'b1}}, 3'b000, '0);
      // R1: single gate bit 8*3+5 picks operand 5 into lane 3 only
      run_op("R1 lane mapping", 64'h0000_5A00_0000_0000 | 64'h0101_0101_0101_0101 & 64'h0,
             64'h1 << (8*3+5), 3'b000, '0);
      // R1: field value 3 behaves as full byte
      run_op("R1 field code 3", 64'h8070_6050_4030_2010, 64'hFF00_AA55_0F0F_F0F0, 3'b011, '0);
      run_op("R1 zero mask", {8{8'hFF}}, '0, 3'b000, '0);
      // R3: low nibble
      run_op("R3 low nibble max", {8{8'hFF}}, {64{1'b1}}, 3'b001, '0);
      run_op("R3 low of 0xF0", {8{8'hF0}}, {64{1'b1}}, 3'b001, '0);
      // R4: high nibble unshifted
      run_op("R4 high nibble", {8{8'hF0}}, {64{1'b1}}, 3'b010, '0);
      run_op("R4 high of 0x0F", {8{8'h0F}}, {64{1'b1}}, 3'b010, '0);
      // R5 R6: accumulate wrap and carry
      run_op("R6 accumulate carry", {8{8'h01}}, 64'h0101_0101_0101_0101, 3'b100, {8{16'hFFFF}});
      run_op("R5 accumulate no carry", {8{8'hFF}}, {64{1'b1}}, 3'b100, {8{16'h1234}});
      run_op("R5 accumulate low field", {8{8'hAB}}, {64{1'b1}}, 3'b101, {8{16'hFFF0}});

      // R7 R8: idle cycle with changed inputs holds results, valid drops
      hold_s = sum_o;
      hold_o = ovf_o;
      @(negedge clk_i);
      opnd_i = '1; mask_i = '1; mode_i = 3'b100; acc_i = '1; valid_i = 1'b0;
      @(posedge clk_i);
      @(negedge clk_i);
      check("R8 hold while idle", sum_o, hold_s, ovf_o, hold_o, valid_o, 1'b0);
      check("R7 valid drops", '0, '0, '0, '0, valid_o, 1'b0);

      // Constrained random mix
      for (int k = 0; k < 300; k++) begin
         logic [63:0]  a   = {$urandom, $urandom};
         logic [63:0]  m   = {$urandom, $urandom};
         logic [2:0]   md  = 3'($urandom_range(0, 7));
         logic [127:0] acc = {$urandom, $urandom, $urandom, $urandom};
         if (k % 4 == 0) acc = {8{16'hFF00 | 16'($urandom_range(0, 255))}};
         if (md[2]) run_op("R5 R6 random accumulate", a, m, md, acc);
         else if (md[1:0] == 2'd1) run_op("R3 random low field", a, m, md, acc);
         else if (md[1:0] == 2'd2) run_op("R4 random high field", a, m, md, acc);
         else run_op("R1 R7 random byte", a, m, md, acc);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule